// File: doc/BRIEF.md
# Oscillator Stabilization Wait Controller

This block sits between a free-running internal oscillator and the system clock tree. It decides whether the oscillator should run, and it withholds the clock-ready indication until the oscillator has produced a programmable number of ticks after each start. The run request comes from a software enable bit and a sleep request. Sleep always wins over the enable bit. The block comes out of reset with the oscillator running and a wait already in progress.

The raw oscillator tick reaches the block as a one-cycle pulse in the system clock domain. The block counts these pulses only while the oscillator is running. A 2-bit select picks the length of the wait, and the block samples it at the edge where the oscillator starts. Downstream logic receives a gated enable that carries the raw tick only once the clock is ready, so no pulse escapes during the wait.

Top module: `osc_stab_wait`

## Requirements
- R1: During reset and in the first cycle after it, oscRun is 1, clkReady is 0 and clkEn is 0. The wait that starts from reset uses select code 0.
- R2: When swEnable is 0 at a clock edge, oscRun is 0 after that edge.
- R3: When swEnable is 1 and sleepReq is 0 at a clock edge, oscRun is 1 after that edge.
- R4: When sleepReq is 1 at a clock edge, oscRun and clkReady are both 0 after that edge, whatever the value of swEnable.
- R5: Select code c gives a wait of 2^(BASE_LOG2+3-c) ticks. At the defaults these are 1024, 512, 256 and 128 for codes 0 to 3. A tick counts when oscTick is 1 at an edge where oscRun is already 1 and the run request stays 1. clkReady rises after the edge that counts the last tick of the wait.
- R6: clkReady falls at the same edge as oscRun, whether the stop comes from the enable bit or from sleep. clkReady is never 1 while oscRun is 0.
- R7: Every start re-runs the full wait from zero. This covers leaving sleep with swEnable still 1 and a stop of a single cycle in the middle of a wait.
- R8: waitSel is sampled at the edge where oscRun rises. A change to waitSel while the oscillator runs takes effect only at the next start.
- R9: clkEn equals oscTick ANDed with clkReady, so clkEn stays 0 during the whole wait.
- R10: Ticks that arrive while the oscillator is stopped are not counted, and clkReady cannot be 1 in the cycle after a stopped cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swEnable | input | 1 | Software oscillator enable |
| waitSel | input | 2 | Stabilization wait select code |
| sleepReq | input | 1 | Sleep request; forces the oscillator off |
| oscTick | input | 1 | Raw oscillator tick, one-cycle pulse |
| oscRun | output | 1 | Oscillator run control |
| clkReady | output | 1 | Oscillator clock is stable and usable |
| clkEn | output | 1 | Gated clock enable for downstream logic |

## Verification
The bench builds the block with BASE_LOG2 set to 2, which shortens the four waits to 32, 16, 8 and 4 ticks. This makes every select code reachable many times within a short run. With the short waits the bench can walk through reset, enable-off, sleep entry with either enable value, a one-cycle stop in the middle of a wait and select changes during a wait. It does so with ticks that arrive every cycle and with ticks that arrive sparsely.

// File: rtl/osc_stab_wait_pkg.sv
package osc_stab_wait_pkg;
  // Strobes issued by the control FSM to the wait datapath
  typedef struct packed {
    logic clear;    // zero the tick counter
    logic count;    // advance the tick counter by one
    logic loadSel;  // track the wait select while stopped
  } oswStrobe_t;
endpackage

// File: rtl/osw_datapath.sv
module osw_datapath #(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  osc_stab_wait_pkg::oswStrobe_t strb,
  input  logic [SEL_W-1:0]              waitSel,
  output logic                          waitDone
);
  localparam int NUM_CODES = 1 << SEL_W;
  localparam int MAX_EXP   = BASE_LOG2 + NUM_CODES - 1;
  localparam int CNT_W     = MAX_EXP + 1;

  logic [CNT_W-1:0] limitTab [NUM_CODES];
  logic [CNT_W-1:0] cntQ;
  logic [SEL_W-1:0] selQ;

  // Wait-length table: code g selects 2^(MAX_EXP-g) ticks
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_limit
    localparam int EXP = MAX_EXP - g;
    assign limitTab[g] = CNT_W'(1) << EXP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (strb.loadSel) begin
      selQ <= waitSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.clear) begin
      cntQ <= '0;
    end else if (strb.count) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign waitDone = strb.count && (cntQ == (limitTab[selQ] - 1'b1));
endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          swEnable,
  input  logic                          sleepReq,
  input  logic                          oscTick,
  input  logic                          waitDone,
  output osc_stab_wait_pkg::oswStrobe_t strb,
  output logic                          oscRun,
  output logic                          clkReady
);
  logic runNext;
  logic runQ;
  logic readyQ;

  assign runNext = swEnable & ~sleepReq;

  always_comb begin
    strb.clear   = ~runNext;
    strb.loadSel = ~runQ;
    strb.count   = runQ & runNext & ~readyQ & oscTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b1;
      readyQ <= 1'b0;
    end else begin
      runQ <= runNext;
      if (!runNext) begin
        readyQ <= 1'b0;
      end else if (waitDone) begin
        readyQ <= 1'b1;
      end
    end
  end

  assign oscRun   = runQ;
  assign clkReady = readyQ;
endmodule

// File: rtl/osc_stab_wait.sv
module osc_stab_wait #(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swEnable,
  input  logic [SEL_W-1:0] waitSel,
  input  logic             sleepReq,
  input  logic             oscTick,
  output logic             oscRun,
  output logic             clkReady,
  output logic             clkEn
);
  osc_stab_wait_pkg::oswStrobe_t strb;
  logic waitDone;

  osw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .swEnable (swEnable),
    .sleepReq (sleepReq),
    .oscTick  (oscTick),
    .waitDone (waitDone),
    .strb     (strb),
    .oscRun   (oscRun),
    .clkReady (clkReady)
  );

  osw_datapath #(
    .BASE_LOG2 (BASE_LOG2),
    .SEL_W     (SEL_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .waitSel  (waitSel),
    .waitDone (waitDone)
  );

  assign clkEn = oscTick & clkReady;
endmodule

// File: rtl/osc_stab_wait_chk.sv
module osc_stab_wait_chk (
  input logic clk,
  input logic rstN,
  input logic swEnable,
  input logic sleepReq,
  input logic oscTick,
  input logic oscRun,
  input logic clkReady
);
  p_disable_stops_r2: assert property (@(posedge clk) disable iff (!rstN)
    !swEnable |=> !oscRun);

  p_enable_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && !sleepReq) |=> oscRun);

  p_sleep_stops_r4: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (!oscRun && !clkReady));

  p_ready_after_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkReady) |-> ($past(oscTick) && $past(oscRun)));

  p_ready_needs_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkReady |-> oscRun);

  p_start_not_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscRun) |-> !clkReady);

  p_stopped_no_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    !oscRun |=> !clkReady);
endmodule

bind osc_stab_wait osc_stab_wait_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .swEnable (swEnable),
  .sleepReq (sleepReq),
  .oscTick  (oscTick),
  .oscRun   (oscRun),
  .clkReady (clkReady)
);

// File: tb/tb_osc_stab_wait.sv
`timescale 1ns/1ps
module tb_osc_stab_wait;
  localparam int B = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swEnable = 1'b1;
  logic [1:0] waitSel = 2'd3;
  logic sleepReq = 1'b0;
  logic oscTick = 1'b0;
  logic oscRun, clkReady, clkEn;

  int testCnt = 0;
  int failCnt = 0;
  string curReq = "R1";

  // reference model state
  bit mRun = 1'b1;
  bit mReady = 1'b0;
  int mCnt = 0;
  int mSel = 0;

  always #4 clk = ~clk;

  osc_stab_wait #(.BASE_LOG2(B), .SEL_W(2)) dut (
    .clk(clk), .rstN(rstN), .swEnable(swEnable), .waitSel(waitSel),
    .sleepReq(sleepReq), .oscTick(oscTick),
    .oscRun(oscRun), .clkReady(clkReady), .clkEn(clkEn)
  );

  function automatic int waitLen(int code);
    return 1 << (B + 3 - code);
  endfunction

  // behavioural model: advance at each edge
  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 1; mReady = 0; mCnt = 0; mSel = 0;
    end else begin
      bit req;
      bit oldRun;
      req = swEnable && !sleepReq;
      oldRun = mRun;
      if (!req) begin
        mRun = 0; mReady = 0; mCnt = 0;
      end else begin
        if (oldRun && !mReady && oscTick) begin
          mCnt++;
          if (mCnt == waitLen(mSel)) mReady = 1;
        end
        mRun = 1;
      end
      if (!oldRun) mSel = waitSel;
    end
  end

  task automatic check1(string what, logic act, logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      check1("oscRun", oscRun, mRun);
      check1("clkReady", clkReady, mReady);
      check1("clkEn R9", clkEn, oscTick & mReady);
    end
  end

  int tickPeriod = 2;
  int tickPhase = 0;

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickPhase++;
      oscTick = (tickPeriod != 0) && (tickPhase % tickPeriod == 0);
    end
  endtask

  task automatic doSummary();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    #200000;
    testCnt++;
    failCnt++;
    $display("FAIL watchdog expired act=hung exp=done");
    doSummary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    testCnt++;
    if (!(oscRun === 1'b1 && clkReady === 1'b0 && clkEn === 1'b0)) begin
      failCnt++;
      $display("FAIL R1 reset outputs act=%0d%0d%0d exp=100", oscRun, clkReady, clkEn);
    end
    rstN = 1'b1;
    curReq = "R1";
    step(1);
    curReq = "R5";  // first wait uses code 0 (32 ticks), not waitSel=3
    step(80);
    // R2/R6/R10: disable with ticks arriving
    curReq = "R2";
    swEnable = 0;
    tickPeriod = 1;
    step(10);
    // R3/R5/R8: restart with code 2 (8 ticks)
    curReq = "R3";
    waitSel = 2;
    swEnable = 1;
    tickPeriod = 2;
    step(30);
    // R4: sleep with enable 1
    curReq = "R4";
    sleepReq = 1;
    step(8);
    swEnable = 0;
    step(4);
    swEnable = 1;
    step(4);
    // R7/R8: leave sleep, change select mid-wait
    curReq = "R7";
    waitSel = 1;
    sleepReq = 0;
    step(5);
    curReq = "R8";
    waitSel = 3;
    step(50);
    // R7: one-cycle stop mid-wait restarts from zero with code 3
    curReq = "R7";
    swEnable = 0;
    step(1);
    swEnable = 1;
    tickPeriod = 1;
    step(2);
    swEnable = 0;
    step(1);
    swEnable = 1;
    step(12);
    // R5: code 0 with sparse ticks
    curReq = "R5";
    waitSel = 0;
    swEnable = 0;
    step(2);
    swEnable = 1;
    tickPeriod = 3;
    step(120);
    // R9: no ticks for a while, then ticks
    curReq = "R9";
    tickPeriod = 0;
    step(5);
    tickPeriod = 1;
    step(5);
    // R10: ticks while stopped by sleep are not counted
    curReq = "R10";
    waitSel = 3;
    sleepReq = 1;
    step(10);
    sleepReq = 0;
    step(10);
    // R6: sleep drops ready together with run
    curReq = "R6";
    sleepReq = 1;
    step(3);
    sleepReq = 0;
    step(10);
    // reset mid-run then check R1 again
    curReq = "R1";
    rstN = 0;
    step(2);
    rstN = 1;
    tickPeriod = 1;
    step(40);
    doSummary();
  end
endmodule